// File: doc/BRIEF.md
# SM2 Prime-Field Product Reducer

This block takes a 512-bit integer product and returns its residue modulo the 256-bit SM2 prime p = 2^256 − 2^224 − 2^96 + 2^64 − 1. It can also take off a 256-bit operand in the same pass, so it yields (c − a) mod p. This lets a modular subtraction that would otherwise follow a multiplication be merged into the reduction. When nothing is to be merged, the operand is driven to zero.

The reduction is split into two folds. The first fold gathers the upper eight 32-bit words of the product into word-aligned terms. It adds and subtracts these terms together with p in one carry-save tree, and produces a 261-bit intermediate. Subtrahends enter the tree as ones-complements, and a single constant carries the missing +1s. The second fold takes the 5 bits above bit 255 and feeds them back at word positions 7, 3, 2 and 0. The result is below 2p, so one compare-and-subtract finishes the job. The datapath is purely combinational between an input strobe and a result register, which gives a latency of one cycle.

Top module: `sm2_fold_reducer`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `out_res` equals (`in_prod` − `in_sub`) mod p, for any `in_prod` < 2^512 and any `in_sub` in [0, p).
- R2: Whenever `out_valid` is high, `out_res` is strictly below p.
- R3: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was sampled high, and low otherwise.
- R4: When `in_valid` is low, `out_res` holds its value whatever `in_prod` and `in_sub` carry.
- R5: While `rst_n` is low, `out_valid` and `out_res` are zero, and `in_valid` has no effect.
- R6: With `in_sub` = 0, the result is the plain residue `in_prod` mod p.
- R7: With `in_prod` = 0 and `in_sub` = p − 1, the result is 1.
- R8: With `in_prod` = (p − 1)^2 and `in_sub` = 0, the result is 1.
- R9: An `in_prod` already below p passes through unchanged, and `in_prod` = p gives 0.
- R10: The all-ones 512-bit `in_prod` (the largest input) is reduced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: reduce the operands presented this cycle |
| in_prod | input | 512 | Product c; bits [32k+31:32k] form word k, word 0 least significant |
| in_sub | input | 256 | Operand a to subtract, must lie in [0, p); zero when unused |
| out_valid | output | 1 | High for one cycle when `out_res` carries a new result |
| out_res | output | 256 | Reduced value in [0, p) |

## Verification
A fault in either fold tree, in a term wiring or in the correction constant produces a wrong or out-of-range `out_res` one edge after the offending input. No state survives from one operation to the next, so the error does not persist or grow. Each operation therefore exposes any tree fault it excites on its own. A fault in the valid register or in the result enable shows as `out_valid` misaligned, or as `out_res` changing during idle cycles, in the very next cycle. The boundary operands matter most because they push the intermediates against their carry limits: a zero product with the largest subtrahend, the square of p − 1, p itself and the all-ones product.

// File: rtl/sm2r_pkg.sv
package sm2r_pkg;
  localparam int WORD_W     = 32;
  localparam int SPAN_WORDS = 8;
  localparam int FIELD_W    = WORD_W * SPAN_WORDS;
  localparam int PROD_W     = 2 * FIELD_W;
  localparam int GUARD_W    = 5;
  localparam int FOLD_W     = FIELD_W + GUARD_W;
  localparam int FIN_W      = FIELD_W + 2;
  localparam int NEG_TERMS  = 5;

  localparam logic [FIELD_W-1:0] PRIME =
    256'hFFFFFFFE_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_00000000_FFFFFFFF_FFFFFFFF;

  typedef struct packed {
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/sm2r_csa_row.sv
module sm2r_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] majority;

  assign sum      = x ^ y ^ z;
  assign majority = (x & y) | (x & z) | (y & z);
  assign carry    = {majority[W-2:0], 1'b0};
endmodule

// File: rtl/sm2r_fold_tree.sv
module sm2r_fold_tree #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic [N-1:0][W-1:0] ops,
  output logic [W-1:0]        total
);
  localparam int ROWS = N - 2;

  logic [W-1:0] sumC [ROWS+1];
  logic [W-1:0] carC [ROWS+1];

  assign sumC[0] = ops[0];
  assign carC[0] = ops[1];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    sm2r_csa_row #(.W(W)) u_row (
      .x    (sumC[i]),
      .y    (carC[i]),
      .z    (ops[i+2]),
      .sum  (sumC[i+1]),
      .carry(carC[i+1])
    );
  end

  assign total = sumC[ROWS] + carC[ROWS];
endmodule

// File: rtl/sm2r_datapath.sv
module sm2r_datapath
  import sm2r_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         strobe,
  input  logic [PROD_W-1:0]  prodIn,
  input  logic [FIELD_W-1:0] subIn,
  output logic [FIELD_W-1:0] resOut
);
  localparam int STAGE1_OPS = 18;
  localparam int STAGE2_OPS = 4;
  localparam logic [FOLD_W-1:0] NEG_FIX = FOLD_W'(NEG_TERMS);
  localparam logic [WORD_W-1:0] ZW = '0;

  logic [WORD_W-1:0] cw [2*SPAN_WORDS];

  for (genvar k = 0; k < 2*SPAN_WORDS; k++) begin : g_word
    assign cw[k] = prodIn[k*WORD_W +: WORD_W];
  end

  // Positive terms, word 7 first
  logic [FIELD_W-1:0] addLow, addW15, addW14, addW13, addMix12;
  logic [FIELD_W-1:0] addW11, addW10, addW9, addW8, addW12;
  // Subtrahends
  logic [FIELD_W-1:0] subW14, subW98, subW13, subW8;

  assign addLow   = prodIn[FIELD_W-1:0];
  assign addW15   = {cw[15], ZW, ZW, ZW, ZW, ZW, ZW, cw[8]};
  assign addW14   = {cw[14], ZW, ZW, cw[14], cw[14], ZW, cw[14], cw[14]};
  assign addW13   = {cw[13], ZW, ZW, ZW, cw[13], ZW, cw[13], cw[13]};
  assign addMix12 = {cw[12], ZW, cw[15], ZW, ZW, ZW, cw[15], cw[15]};
  assign addW11   = {cw[11], cw[11], cw[13], cw[13], cw[11], ZW, cw[11], cw[11]};
  assign addW10   = {cw[10], cw[15], cw[10], ZW, ZW, ZW, cw[10], cw[10]};
  assign addW9    = {cw[9], cw[14], cw[14], cw[15], cw[15], ZW, cw[9], cw[9]};
  assign addW8    = {cw[8], ZW, ZW, cw[9], cw[8], ZW, ZW, ZW};
  assign addW12   = {ZW, ZW, ZW, cw[12], cw[12], ZW, cw[12], cw[12]};

  assign subW14   = {ZW, ZW, ZW, ZW, cw[14], cw[14], ZW, ZW};
  assign subW98   = {ZW, ZW, ZW, ZW, ZW, cw[9], ZW, cw[8]};
  assign subW13   = {ZW, ZW, ZW, ZW, ZW, cw[13], cw[13], ZW};
  assign subW8    = {ZW, ZW, ZW, ZW, ZW, cw[8], ZW, cw[8]};

  // Stage one: 18 operands into a 261-bit intermediate
  logic [STAGE1_OPS-1:0][FOLD_W-1:0] ops1;
  logic [FOLD_W-1:0] foldOne;

  assign ops1[0]  = {{GUARD_W{1'b0}}, addLow};
  assign ops1[1]  = {{GUARD_W{1'b0}}, addW15};
  assign ops1[2]  = {{(GUARD_W-1){1'b0}}, addW15, 1'b0};
  assign ops1[3]  = {{(GUARD_W-1){1'b0}}, addW14, 1'b0};
  assign ops1[4]  = {{(GUARD_W-1){1'b0}}, addW13, 1'b0};
  assign ops1[5]  = {{(GUARD_W-1){1'b0}}, addMix12, 1'b0};
  assign ops1[6]  = {{GUARD_W{1'b0}}, addW11};
  assign ops1[7]  = {{GUARD_W{1'b0}}, addW10};
  assign ops1[8]  = {{GUARD_W{1'b0}}, addW9};
  assign ops1[9]  = {{GUARD_W{1'b0}}, addW8};
  assign ops1[10] = {{GUARD_W{1'b0}}, addW12};
  assign ops1[11] = {{GUARD_W{1'b0}}, PRIME};
  assign ops1[12] = ~{{GUARD_W{1'b0}}, subW14};
  assign ops1[13] = ~{{GUARD_W{1'b0}}, subW98};
  assign ops1[14] = ~{{GUARD_W{1'b0}}, subW13};
  assign ops1[15] = ~{{GUARD_W{1'b0}}, subW8};
  assign ops1[16] = ~{{GUARD_W{1'b0}}, subIn};
  assign ops1[17] = NEG_FIX;

  sm2r_fold_tree #(.W(FOLD_W), .N(STAGE1_OPS)) u_stage1 (
    .ops  (ops1),
    .total(foldOne)
  );

  // Stage two: fold the guard word back in
  logic [GUARD_W-1:0] topWord;
  logic [FIN_W-1:0]   spread, minusTop, foldTwo;
  logic [STAGE2_OPS-1:0][FIN_W-1:0] ops2;

  assign topWord  = foldOne[FOLD_W-1:FIELD_W];
  assign spread   = (FIN_W'(topWord) << 224) | (FIN_W'(topWord) << 96) | FIN_W'(topWord);
  assign minusTop = ~(FIN_W'(topWord) << 64);

  assign ops2[0] = {2'b00, foldOne[FIELD_W-1:0]};
  assign ops2[1] = spread;
  assign ops2[2] = minusTop;
  assign ops2[3] = FIN_W'(1);

  sm2r_fold_tree #(.W(FIN_W), .N(STAGE2_OPS)) u_stage2 (
    .ops  (ops2),
    .total(foldTwo)
  );

  // Final conditional subtraction
  logic               overPrime;
  logic [FIELD_W-1:0] resNext;

  assign overPrime = foldTwo >= {2'b00, PRIME};
  assign resNext   = overPrime ? (foldTwo[FIELD_W-1:0] - PRIME) : foldTwo[FIELD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           resOut <= '0;
    else if (strobe.load) resOut <= resNext;
  end
endmodule

// File: rtl/sm2r_ctrl.sv
module sm2r_ctrl
  import sm2r_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output ctlStrobe_t strobe,
  output logic       outValid
);
  assign strobe.load = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/sm2_fold_reducer.sv
module sm2_fold_reducer
  import sm2r_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PROD_W-1:0]  in_prod,
  input  logic [FIELD_W-1:0] in_sub,
  output logic               out_valid,
  output logic [FIELD_W-1:0] out_res
);
  ctlStrobe_t strobe;

  sm2r_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (in_valid),
    .strobe  (strobe),
    .outValid(out_valid)
  );

  sm2r_datapath u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .prodIn(in_prod),
    .subIn (in_sub),
    .resOut(out_res)
  );
endmodule

// File: rtl/sm2r_checker.sv
module sm2r_checker
  import sm2r_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [FIELD_W-1:0] out_res
);
  a_r2_below_prime: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_res < PRIME));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res));
endmodule

bind sm2_fold_reducer sm2r_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_res  (out_res)
);

// File: tb/sim_sm2_fold_reducer.sv
module sim_sm2_fold_reducer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] in_prod = '0;
  logic [255:0] in_sub = '0;
  logic         out_valid;
  logic [255:0] out_res;

  int checks = 0;
  int errors = 0;

  logic [519:0] pBig;
  logic [255:0] pVal;

  always #2 clk = ~clk;

  sm2_fold_reducer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_prod(in_prod), .in_sub(in_sub),
    .out_valid(out_valid), .out_res(out_res)
  );

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [255:0] model(input logic [511:0] c, input logic [255:0] a);
    logic [519:0] cm;
    cm = {8'd0, c} % pBig;
    cm = (cm + pBig - {264'd0, a}) % pBig;
    return cm[255:0];
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  // One operation: R1 result, R2 range, R3 valid timing, R4 hold
  task automatic apply(input string tag, input logic [511:0] c, input logic [255:0] a);
    logic [255:0] exp;
    logic [255:0] held;
    exp = model(c, a);
    @(negedge clk);
    in_valid = 1'b1; in_prod = c; in_sub = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R3 valid high"}, 256'(out_valid), 256'd1);
    check(tag, out_res, exp);
    check({tag, " R2 below p"}, 256'(out_res < pVal), 256'd1);
    held = out_res;
    in_prod = ~c; in_sub = a ^ 256'h5a5a;
    @(negedge clk);
    check({tag, " R3 valid low"}, 256'(out_valid), 256'd0);
    check({tag, " R4 hold"}, out_res, held);
  endtask

  task automatic t_reset();
    in_valid = 1'b1; in_prod = rand512(); in_sub = 256'd7;
    repeat (3) @(negedge clk);
    check("R5 reset valid", 256'(out_valid), 256'd0);
    check("R5 reset result", out_res, 256'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 after release", 256'(out_valid), 256'd0);
  endtask

  task automatic t_corners();
    apply("R7 zero minus p-1", 512'd0, pVal - 256'd1);
    check("R7 value", out_res, 256'd1);
    apply("R1 zero", 512'd0, 256'd0);
    apply("R8 square of p-1", 512'(pVal - 256'd1) * 512'(pVal - 256'd1), 256'd0);
    check("R8 value", out_res, 256'd1);
    apply("R9 p-1 passes", 512'(pVal - 256'd1), 256'd0);
    check("R9 value", out_res, pVal - 256'd1);
    apply("R9 p gives zero", 512'(pVal), 256'd0);
    check("R9 zero value", out_res, 256'd0);
    apply("R9 small", 512'd12345, 256'd0);
    check("R9 small value", out_res, 256'd12345);
    apply("R10 all ones", {512{1'b1}}, 256'd0);
    apply("R10 all ones minus p-1", {512{1'b1}}, pVal - 256'd1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 80; n++) begin
      logic [511:0] c;
      logic [255:0] a;
      c = rand512();
      a = rand512() % {256'd0, pVal};
      if (n % 2 == 0) apply("R6 random a=0", c, 256'd0);
      else            apply("R1 random", c, a);
    end
  endtask

  task automatic t_backtoback();
    logic [511:0] c1;
    logic [511:0] c2;
    c1 = rand512(); c2 = rand512();
    @(negedge clk);
    in_valid = 1'b1; in_prod = c1; in_sub = 256'd3;
    @(negedge clk);
    check("R3 burst first valid", 256'(out_valid), 256'd1);
    check("R1 burst first", out_res, model(c1, 256'd3));
    in_prod = c2; in_sub = 256'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 burst second valid", 256'(out_valid), 256'd1);
    check("R1 burst second", out_res, model(c2, 256'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pBig = (520'd1 << 256) - (520'd1 << 224) - (520'd1 << 96) + (520'd1 << 64) - 520'd1;
    pVal = pBig[255:0];
    t_reset();
    t_corners();
    t_backtoback();
    t_random();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule